// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shifter

This block is the logic core of a display row scanner. A start pulse is captured on the rising edge of the shift clock and walks through a chain of row stages, one stage per clock. The direction is chosen by an up/down level. Each stage drives one row output. Rows fall into three interleaved groups, and each group has its own blanking input that can hold its rows inactive.

A shortened mode removes eight middle rows from the chain, so a 128-row part can serve a 120-row panel. The two start pins swap roles with the direction. In each direction one pin takes the incoming start pulse and the other passes the pulse from the last stage to the next scanner in a cascade. Each bidirectional pin is split into an input, an output and a drive flag. Level shifting and high-voltage output stages lie outside this block.

Top module: `gate_scan_shifter`

## Requirements
- R1: On every rising edge of `clk_i` the first stage of the active chain samples the start input, and every other stage takes the value its predecessor held before the edge. A pulse applied for one clock therefore occupies chain position k after the k-th rising edge.
- R2: With `up_i` high, `pin_a_i` is the start input and the chain runs from row index 0 to row index 127. With `up_i` low, `pin_b_i` is the start input and the chain runs from index 127 down to index 0.
- R3: On every falling edge of `clk_i` the cascade output register loads the last stage of the current direction: row 127 when going up, row 0 when going down. A single pulse appears on the cascade pin at the falling edge of the L-th clock, where L is the active chain length (128 or 120).
- R4: With `short_i` high, row indices 60 to 67 leave the chain. Index 59 feeds index 68 going up, and index 68 feeds index 59 going down. Bypassed rows hold 0 and their outputs stay low.
- R5: `row_o[i]` is high only when its stage holds 1 and the blanking bit of its group is low. A high blanking bit forces every row of that group low, whatever the stored data.
- R6: With `short_i` low, row index i belongs to group i mod 3, and `blank_i[g]` controls group g.
- R7: With `short_i` high, rows 0 to 59 belong to group i mod 3 and rows 68 to 127 belong to group (i-8) mod 3. Each group follows its position in the shortened chain.
- R8: `pin_b_oe_o` equals `up_i` and `pin_a_oe_o` is its inverse, so exactly one pin drives. The cascade value appears on the driving pin, and the non-driving output is 0.
- R9: `rst_ni` low asynchronously clears all stages, all row outputs and the cascade register.
- R10: Several pulses in the chain travel independently, each advancing one position per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Scan direction: 1 = ascending row index |
| short_i | input | 1 | 1 = 120-row chain with rows 60..67 bypassed |
| blank_i | input | 3 | Per-group blanking, 1 forces the group's rows low |
| pin_a_i | input | 1 | Start pin A input value (start input when up_i=1) |
| pin_a_o | output | 1 | Start pin A output value (cascade when up_i=0) |
| pin_a_oe_o | output | 1 | Pin A drive enable |
| pin_b_i | input | 1 | Start pin B input value (start input when up_i=0) |
| pin_b_o | output | 1 | Start pin B output value (cascade when up_i=1) |
| pin_b_oe_o | output | 1 | Pin B drive enable |
| row_o | output | 128 | Row (gate line) outputs, index 0 = first row |

## Verification
Several properties are checked on every cycle:
- Stage-to-stage transfer and start capture in both directions.
- The join across the bypass gap and the idle state of the bypassed rows.
- The cascade pin following the end stage of the current direction.
- Forced-low rows under blanking.

Other behaviour only shows up in the bench scenarios:
- The end-to-end latency of a pulse over 128 and 120 stages.
- The group assignment of every row under all eight blanking combinations.
- Several pulses travelling together.
- An asynchronous reset in the middle of a frame.

These scenarios are checked against a behavioural model of the chain order.

// File: rtl/gss_pkg.sv
package gss_pkg;

  // Group of a row index, counted by its position in the active chain.
  function automatic int grp_of(int idx, bit short_mode, int byp_first,
                                int byp_len, int n_grp);
    int pos;
    pos = (short_mode && idx >= byp_first + byp_len) ? idx - byp_len : idx;
    return pos % n_grp;
  endfunction

endpackage

// File: rtl/gss_chain.sv
module gss_chain #(
  parameter int N_ROWS    = 128,
  parameter int BYP_FIRST = 60,
  parameter int BYP_LEN   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_i,
  input  logic              short_i,
  input  logic              start_i,
  output logic [N_ROWS-1:0] stage_o
);

  localparam int BYP_LAST = BYP_FIRST + BYP_LEN - 1;

  logic [N_ROWS-1:0] q, nxt, up_src, dn_src;

  for (genvar i = 0; i < N_ROWS; i++) begin : g_stage
    if (i == 0) begin : g_up_head
      assign up_src[i] = start_i;
    end else if (i == BYP_LAST + 1) begin : g_up_join
      assign up_src[i] = short_i ? q[BYP_FIRST-1] : q[i-1];
    end else begin : g_up_mid
      assign up_src[i] = q[i-1];
    end

    if (i == N_ROWS - 1) begin : g_dn_head
      assign dn_src[i] = start_i;
    end else if (i == BYP_FIRST - 1) begin : g_dn_join
      assign dn_src[i] = short_i ? q[BYP_LAST+1] : q[i+1];
    end else begin : g_dn_mid
      assign dn_src[i] = q[i+1];
    end

    if (i >= BYP_FIRST && i <= BYP_LAST) begin : g_byp
      assign nxt[i] = short_i ? 1'b0 : (up_i ? up_src[i] : dn_src[i]);
    end else begin : g_norm
      assign nxt[i] = up_i ? up_src[i] : dn_src[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign stage_o = q;

  AST_CAPTURE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_i |=> q[0] == $past(start_i)); // R1
  AST_CAPTURE_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_i |=> q[N_ROWS-1] == $past(start_i)); // R2
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_i |=> q[1] == $past(q[0])); // R1
  AST_SHIFT_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_i |=> q[N_ROWS-2] == $past(q[N_ROWS-1])); // R2
  AST_BYPASS_JOIN_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_i && up_i |=> q[BYP_LAST+1] == $past(q[BYP_FIRST-1])); // R4
  AST_BYPASS_JOIN_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_i && !up_i |=> q[BYP_FIRST-1] == $past(q[BYP_LAST+1])); // R4
  AST_BYPASS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_i |=> q[BYP_LAST:BYP_FIRST] == '0); // R4

endmodule

// File: rtl/gss_gate.sv
module gss_gate #(
  parameter int N_ROWS    = 128,
  parameter int BYP_FIRST = 60,
  parameter int BYP_LEN   = 8,
  parameter int N_GRP     = 3
) (
  input  logic [N_ROWS-1:0] stage_i,
  input  logic              short_i,
  input  logic [N_GRP-1:0]  blank_i,
  output logic [N_ROWS-1:0] row_o
);

  localparam int BYP_LAST = BYP_FIRST + BYP_LEN - 1;

  for (genvar i = 0; i < N_ROWS; i++) begin : g_row
    localparam int GL = gss_pkg::grp_of(i, 1'b0, BYP_FIRST, BYP_LEN, N_GRP);
    localparam int GS = gss_pkg::grp_of(i, 1'b1, BYP_FIRST, BYP_LEN, N_GRP);
    logic blk;
    assign blk = short_i ? blank_i[GS] : blank_i[GL];
    if (i >= BYP_FIRST && i <= BYP_LAST) begin : g_byp
      assign row_o[i] = stage_i[i] & ~blk & ~short_i;
    end else begin : g_norm
      assign row_o[i] = stage_i[i] & ~blk;
    end
  end

endmodule

// File: rtl/gss_cascade.sv
module gss_cascade (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic first_i,
  input  logic last_i,
  input  logic pin_a_i,
  input  logic pin_b_i,
  output logic start_o,
  output logic pin_a_o,
  output logic pin_a_oe_o,
  output logic pin_b_o,
  output logic pin_b_oe_o
);

  logic casc_q;

  // Falling-edge launch gives the next scanner half a clock of setup.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) casc_q <= 1'b0;
    else         casc_q <= up_i ? last_i : first_i;
  end

  assign start_o    = up_i ? pin_a_i : pin_b_i;
  assign pin_b_oe_o = up_i;
  assign pin_a_oe_o = ~up_i;
  assign pin_b_o    = up_i & casc_q;
  assign pin_a_o    = ~up_i & casc_q;

  AST_CASCADE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_i && $stable(up_i) |-> pin_b_o == last_i); // R3
  AST_CASCADE_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_i && $stable(up_i) |-> pin_a_o == first_i); // R3
  AST_IDLE_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pin_a_o && pin_b_o)); // R8

endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter #(
  parameter int N_ROWS    = 128,
  parameter int BYP_FIRST = 60,
  parameter int BYP_LEN   = 8,
  parameter int N_GRP     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_i,
  input  logic              short_i,
  input  logic [N_GRP-1:0]  blank_i,
  input  logic              pin_a_i,
  output logic              pin_a_o,
  output logic              pin_a_oe_o,
  input  logic              pin_b_i,
  output logic              pin_b_o,
  output logic              pin_b_oe_o,
  output logic [N_ROWS-1:0] row_o
);

  logic              start;
  logic [N_ROWS-1:0] stage;

  gss_cascade u_casc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_i       (up_i),
    .first_i    (stage[0]),
    .last_i     (stage[N_ROWS-1]),
    .pin_a_i    (pin_a_i),
    .pin_b_i    (pin_b_i),
    .start_o    (start),
    .pin_a_o    (pin_a_o),
    .pin_a_oe_o (pin_a_oe_o),
    .pin_b_o    (pin_b_o),
    .pin_b_oe_o (pin_b_oe_o)
  );

  gss_chain #(.N_ROWS(N_ROWS), .BYP_FIRST(BYP_FIRST), .BYP_LEN(BYP_LEN)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .up_i    (up_i),
    .short_i (short_i),
    .start_i (start),
    .stage_o (stage)
  );

  gss_gate #(.N_ROWS(N_ROWS), .BYP_FIRST(BYP_FIRST), .BYP_LEN(BYP_LEN),
             .N_GRP(N_GRP)) u_gate (
    .stage_i (stage),
    .short_i (short_i),
    .blank_i (blank_i),
    .row_o   (row_o)
  );

  AST_BLANK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i[0] |-> !row_o[0]); // R5
  AST_GROUP_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !short_i && blank_i[(N_ROWS-1) % N_GRP] |-> !row_o[N_ROWS-1]); // R6
  AST_GROUP_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_i && blank_i[(N_ROWS-1-BYP_LEN) % N_GRP] |-> !row_o[N_ROWS-1]); // R7
  AST_ROW_NEEDS_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_o & ~stage) == '0); // R5

endmodule

// File: tb/gate_scan_shifter_test.sv
module gate_scan_shifter_test;
  localparam int N = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up = 1'b1, short_m = 1'b0, pa = 1'b0, pb = 1'b0;
  logic [2:0] blank = 3'b000;
  logic pa_o, pa_oe, pb_o, pb_oe;
  logic [N-1:0] rows;

  int checks = 0, fails = 0;
  bit m[N];
  bit casc_m = 1'b0;

  always #5 clk = ~clk;

  gate_scan_shifter uut (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .short_i(short_m), .blank_i(blank),
    .pin_a_i(pa), .pin_a_o(pa_o), .pin_a_oe_o(pa_oe),
    .pin_b_i(pb), .pin_b_o(pb_o), .pin_b_oe_o(pb_oe), .row_o(rows)
  );

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Chain order in ascending direction, bypassed rows left out.
  function automatic void build_order(ref int ord[$]);
    ord.delete();
    for (int r = 0; r < N; r++)
      if (!(short_m && r >= 60 && r <= 67)) ord.push_back(r);
  endfunction

  function automatic logic [N-1:0] exp_rows();
    int ord[$];
    logic [N-1:0] v = '0;
    build_order(ord);
    foreach (ord[k]) if (m[ord[k]] && !blank[k % 3]) v[ord[k]] = 1'b1;
    return v;
  endfunction

  task automatic model_shift();
    int ord[$];
    bit nm[N];
    build_order(ord);
    if (!up) ord.reverse();
    foreach (nm[r]) nm[r] = 1'b0;
    nm[ord[0]] = up ? pa : pb;
    for (int k = 1; k < ord.size(); k++) nm[ord[k]] = m[ord[k-1]];
    m = nm;
  endtask

  task automatic chk_pins();
    logic [3:0] act, exp;
    act = {pa_o, pa_oe, pb_o, pb_oe};
    exp = {~up & casc_m, ~up, up & casc_m, up};
    chk(act == exp, "R2 R3 R8 pins", N'(act), N'(exp));
  endtask

  task automatic step();
    @(posedge clk);
    model_shift();
    #2;
    chk(rows == exp_rows(), short_m ? "R1 R4 R7 R10 rows" : "R1 R5 R6 R10 rows",
        rows, exp_rows());
    chk_pins();
    @(negedge clk);
    casc_m = up ? m[N-1] : m[0];
    #2;
    chk_pins();
  endtask

  task automatic frame(input bit dir, input bit shrt);
    int first_hit = -1, len;
    len = shrt ? 120 : 128;
    up = dir; short_m = shrt; blank = 3'b000;
    if (dir) pa = 1'b1; else pb = 1'b1;
    step();
    pa = 1'b0; pb = 1'b0;
    for (int k = 2; k <= len + 4; k++) begin
      step();
      if (first_hit < 0 && (dir ? pb_o : pa_o)) first_hit = k;
    end
    chk(first_hit == len, "R1 R3 cascade latency", N'(first_hit), N'(len));
  endtask

  task automatic pattern(input bit dir, input bit shrt, input int n);
    up = dir; short_m = shrt;
    for (int k = 0; k < n; k++) begin
      blank = 3'(k / 4);
      if (dir) pa = (k % 5 == 0); else pb = (k % 7 == 0);
      step();
    end
    pa = 1'b0; pb = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (m[r]) m[r] = 1'b0;
    #12;
    chk(rows == '0, "R9 reset rows", rows, '0);
    chk({pa_o, pb_o} == 2'b00, "R9 reset pins", N'({pa_o, pb_o}), '0);
    @(negedge clk); #2; rst_n = 1'b1;

    frame(1'b1, 1'b0);
    frame(1'b0, 1'b0);
    frame(1'b1, 1'b1);
    frame(1'b0, 1'b1);

    pattern(1'b1, 1'b0, 200);   // R6 every blanking combination
    pattern(1'b0, 1'b0, 200);
    pattern(1'b1, 1'b1, 200);   // R7 every blanking combination
    pattern(1'b0, 1'b1, 200);

    // R9 asynchronous reset in mid-frame
    pattern(1'b1, 1'b0, 40);
    blank = 3'b000;
    rst_n = 1'b0;
    #1;
    chk(rows == '0, "R9 async reset rows", rows, '0);
    chk({pa_o, pb_o} == 2'b00, "R9 async reset pins", N'({pa_o, pb_o}), '0);
    foreach (m[r]) m[r] = 1'b0;
    casc_m = 1'b0;
    @(negedge clk); #2; rst_n = 1'b1;
    pattern(1'b0, 1'b0, 30);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule